// File: doc/BRIEF.md
# Rational Sigmoid Activation Unit

This block turns the signed fixed-point net value of a neuron (bias plus weighted input sum) into an unsigned fractional activation. The activation follows the logistic curve closely enough for inference. It evaluates f(x) = (1 + x/(1+|x|)) / 2 and needs neither an exponential nor a lookup table. The datapath has a saturating magnitude stage and an adder that forms the divisor 1 + |x|. A restoring divider then produces one quotient bit per enabled clock. The sign is put back on the quotient, one is added, and the sum is halved by a one-bit shift.

A caller presents `net_in` and pulses `start`. `done` pulses once the result is ready. The block moves only on clock edges where `ce` is high, so it can sit in a clock-enabled pipeline of neurons and be stalled without losing state.

Top module: `sig_rational_act`

## Requirements
- R1: For a net value n in two's-complement Q8.8, the result is computed as follows. Let m = min(|n|, 32767) and q = floor(m*256/(256+m)). Let s = q when n >= 0, and s = -q otherwise. The result is floor((256 + s + 1)/2), limited to the range 0x00..0xFF, and read as an unsigned Q0.8 fraction.
- R2: A net value of 0x0000 gives exactly 0x80, which is one half.
- R3: The input 0x8000 is handled as the magnitude 0x7FFF, so its result equals the result for 0x8001.
- R4: When `start` is high on an enabled edge while the unit is idle, the operation is accepted. `done` rises after the 8th enabled edge that follows the accepting edge, and it stays high for exactly one enabled cycle.
- R5: While `ce` is low, `done`, `result` and the progress of a division all hold.
- R6: A `start` pulse during a division is ignored. The running operation ends on schedule with its own result, and no extra `done` follows.
- R7: `result` changes only on the cycle in which `done` is high, and it keeps its value between operations. Reset sets `result` to 0x00 and `done` to 0.
- R8: Over increasing net values the result never decreases. Large positive inputs approach 0xFF and large negative inputs approach 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable; all state holds while low |
| start | input | 1 | Begin an operation on `net_in` |
| net_in | input | 16 | Signed Q8.8 net value |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 8 | Unsigned Q0.8 activation |

## Verification
The assertions check, on every cycle, the invariants of the restoring divider: the remainder stays below the divisor and the step counter advances during a division. They also check that everything holds while `ce` is low, that `done` pulses once as the divider goes idle, that `result` moves only with `done`, and that the magnitude saturates for 0x8000. The numeric value of the activation, its exact value at zero, its monotonic shape over a sweep and the latency in enabled cycles can only be shown by the bench's scenarios, which compare against an integer model of R1. Scenarios also cover a start pulse during a division and stalls in the middle of a division.

// File: rtl/sig_pkg.sv
package sig_pkg;
  localparam int NET_W    = 16;
  localparam int NET_FRAC = 8;
  localparam int ACT_W    = 8;
  localparam int DIV_W    = NET_W + 1;
  localparam int REM_W    = NET_W + 2;
  localparam int CNT_W    = $clog2(ACT_W + 1);

  // magnitude of a two's-complement value; the most negative code saturates
  function automatic logic [NET_W-1:0] abs_sat(input logic [NET_W-1:0] x);
    if (!x[NET_W-1]) return x;
    if (x == {1'b1, {(NET_W-1){1'b0}}}) return {1'b0, {(NET_W-1){1'b1}}};
    return (~x) + 1'b1;
  endfunction

  // reapply sign, add one, halve with rounding, clamp to the output range
  function automatic logic [ACT_W-1:0] finish_act(input logic neg,
                                                  input logic [ACT_W-1:0] q);
    logic [ACT_W+2:0] one_c, half, qe, t;
    one_c = (ACT_W+3)'(1);
    half  = one_c << ACT_W;
    qe    = (ACT_W+3)'(q);
    t     = neg ? (half - qe + one_c) : (half + qe + one_c);
    if (t[ACT_W+2]) return '0;
    t = t >> 1;
    if (t > (ACT_W+3)'({ACT_W{1'b1}})) return '1;
    return t[ACT_W-1:0];
  endfunction
endpackage

// File: rtl/sig_mag_front.sv
module sig_mag_front
  import sig_pkg::*;
#(
  parameter int W = NET_W,
  parameter int F = NET_FRAC
) (
  input  logic [W-1:0] net,
  output logic [W-1:0] mag,
  output logic [W:0]   dvs,
  output logic         neg
);
  localparam logic [W:0] ONE_FX = (W+1)'(1) << F;

  always_comb begin
    mag = abs_sat(net);
    dvs = {1'b0, mag} + ONE_FX;
    neg = net[W-1];
  end
endmodule

// File: rtl/sig_restore_div.sv
module sig_restore_div
  import sig_pkg::*;
#(
  parameter int W  = NET_W,
  parameter int QW = ACT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               load,
  input  logic [W-1:0]       mag,
  input  logic [W:0]         dvs_in,
  output logic               busy,
  output logic [CNT_W-1:0]   cnt,
  output logic               last,
  output logic [W+1:0]       rem,
  output logic [W:0]         dvs,
  output logic [QW-1:0]      q_next
);
  localparam int RW = W + 2;
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(QW - 1);

  logic [QW-1:0] q;
  logic [RW-1:0] r2, r_next;
  logic          ge;

  always_comb begin
    r2     = {rem[RW-2:0], 1'b0};
    ge     = r2 >= {1'b0, dvs};
    r_next = ge ? (r2 - {1'b0, dvs}) : r2;
    q_next = {q[QW-2:0], ge};
    last   = busy && (cnt == LAST_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dvs  <= '0;
      q    <= '0;
    end else if (ce) begin
      if (load && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
        rem  <= {2'b00, mag};
        dvs  <= dvs_in;
        q    <= '0;
      end else if (busy) begin
        rem <= r_next;
        q   <= q_next;
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sig_rational_act.sv
module sig_rational_act
  import sig_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             start,
  input  logic [NET_W-1:0] net_in,
  output logic             done,
  output logic [ACT_W-1:0] result
);
  logic [NET_W-1:0] mag_w;
  logic [NET_W:0]   dvs_w, dvs_q;
  logic             neg_w, neg_q;
  logic             busy_w, last_w, fin_w;
  logic [CNT_W-1:0] cnt_w;
  logic [NET_W+1:0] rem_w;
  logic [ACT_W-1:0] qn_w;

  sig_mag_front #(.W(NET_W), .F(NET_FRAC)) u_front (
    .net(net_in), .mag(mag_w), .dvs(dvs_w), .neg(neg_w)
  );

  sig_restore_div #(.W(NET_W), .QW(ACT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ce(ce), .load(start),
    .mag(mag_w), .dvs_in(dvs_w),
    .busy(busy_w), .cnt(cnt_w), .last(last_w),
    .rem(rem_w), .dvs(dvs_q), .q_next(qn_w)
  );

  assign fin_w = ce && last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else if (ce) begin
      if (start && !busy_w) neg_q <= neg_w;
      done <= fin_w;
      if (fin_w) result <= finish_act(neg_q, qn_w);
    end
  end
endmodule

// File: rtl/sig_rational_act_chk.sv
module sig_rational_act_chk
  import sig_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ce,
  input logic [NET_W-1:0] net_in,
  input logic             done,
  input logic [ACT_W-1:0] result,
  input logic             busy,
  input logic             last,
  input logic [CNT_W-1:0] cnt,
  input logic [NET_W+1:0] rem,
  input logic [NET_W:0]   dvs,
  input logic [NET_W-1:0] mag
);
  a_r1_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < {1'b0, dvs}));

  a_r3_mag_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (net_in == 16'h8000) |-> (mag == 16'h7FFF));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && done) |=> !done);

  a_r4_done_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(result) && $stable(done) && $stable(busy) && $stable(cnt)));

  a_r6_div_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && busy && !last) |=> (busy && (cnt == $past(cnt) + 1'b1)));

  a_r7_result_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
endmodule

bind sig_rational_act sig_rational_act_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .net_in(net_in),
  .done(done), .result(result), .busy(busy_w), .last(last_w),
  .cnt(cnt_w), .rem(rem_w), .dvs(dvs_q), .mag(mag_w)
);

// File: tb/sig_rational_act_tb.sv
`timescale 1ns/1ps
module sig_rational_act_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b1;
  logic        start = 1'b0;
  logic [15:0] net_in = '0;
  logic        done;
  logic [7:0]  result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #2.5 clk = ~clk;

  sig_rational_act u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .start(start),
    .net_in(net_in), .done(done), .result(result)
  );

  function automatic int model(input int n);
    int m, q, s, v;
    m = (n < 0) ? -n : n;
    if (m > 32767) m = 32767;
    q = (m * 256) / (256 + m);
    s = (n < 0) ? -q : q;
    v = (256 + s + 1) / 2;
    if (v > 255) v = 255;
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns enabled cycles (negedges) until done; result sampled there
  task automatic run_op(input int n, output int lat, output int res);
    @(negedge clk);
    net_in = 16'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (done) begin lat = k; break; end
    end
    res = result;
  endtask

  task automatic t_reset();
    chk("R7 reset done", done, 0);
    chk("R7 reset result", result, 0);
  endtask

  task automatic t_points();
    int lat, res;
    int pts[8] = '{0, 256, -256, 128, -77, 1000, 32767, -32767};
    foreach (pts[i]) begin
      run_op(pts[i], lat, res);
      chk("R1 value", res, model(pts[i]));
      chk("R4 latency", lat, 8);
    end
    run_op(0, lat, res);
    chk("R2 zero gives half", res, 128);
    @(negedge clk);
    chk("R4 done single cycle", done, 0);
  endtask

  task automatic t_minneg();
    int lat, res, ref_r;
    run_op(-32767, lat, ref_r);
    run_op(-32768, lat, res);
    chk("R3 0x8000 equals 0x8001", res, ref_r);
    chk("R3 model", res, model(-32768));
  endtask

  task automatic t_sweep();
    int lat, res, prev;
    prev = -1;
    for (int n = -32768; n < 32768; n += 1024) begin
      run_op(n, lat, res);
      chk("R1 sweep", res, model(n));
      if (res < prev) chk("R8 monotonic", res, prev);
      prev = res;
    end
    chk("R8 top near full", (res >= 250) ? 1 : 0, 1);
    run_op(-32000, lat, res);
    chk("R8 bottom near zero", (res <= 5) ? 1 : 0, 1);
  endtask

  task automatic t_stall();
    int lat;
    @(negedge clk);
    net_in = 16'(700);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 40; k++) begin
      ce = (k >= 3 && k <= 6) ? 1'b0 : 1'b1;
      @(negedge clk);
      if (done) begin lat = k; break; end
    end
    chk("R5 latency with 4 stalled cycles", lat, 12);
    chk("R5 value after stall", result, model(700));
    ce = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 done held while stalled", done, 1);
    chk("R5 result held while stalled", result, model(700));
    ce = 1'b1;
    @(negedge clk);
    chk("R4 done drops after enabled cycle", done, 0);
  endtask

  task automatic t_restart_ignored();
    int lat, extra;
    @(negedge clk);
    net_in = 16'(-2000);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 30; k++) begin
      if (k == 3) begin net_in = 16'(5000); start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      if (done) begin lat = k; break; end
    end
    start = 1'b0;
    chk("R6 latency unchanged", lat, 8);
    chk("R6 first operand result", result, model(-2000));
    extra = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R6 no extra done", extra, 0);
    chk("R7 result holds between ops", result, model(-2000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_points();
    t_minneg();
    t_stall();
    t_restart_ignored();
    t_sweep();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule